// File: doc/BRIEF.md
# Weekly Minute Alarm Comparator

This block watches the time of day produced by a separate calendar counter and raises an interrupt when the time reaches a programmed alarm. The alarm is given as a minute, an hour and a set of weekdays. The minute and hour are in BCD. The weekdays are a bitmask, so one alarm setting can fire on several days of the week. The block only compares at minute granularity. It does this once per minute, on the one-second tick whose new seconds value is 00.

Software programs the alarm through a small register window on the shared register bus. A match sets a sticky pending flag. The flag reaches the interrupt pin only while the alarm enable bit is set. Software clears the flag by writing a one to the status register. While the calendar counter is held for a time update, no match is taken.

Top module: `wk_alarm_top`

## Requirements
- R1: After synchronous reset, the alarm minute, alarm hour, day mask and enable all read 0, the pending flag reads 0 and `alarm_irq` is low.
- R2: The alarm minute register (offset 0x40, bits 6:0) and the alarm hour register (offset 0x44, bits 5:0) hold BCD values. The day mask (offset 0x48, bits 6:0) has bit n selecting weekday n. All three read back what was written, with the unused upper bits reading 0.
- R3: Bit 4 of the control register (offset 0x04) is the alarm enable and reads back. Writing 0 to that register clears the enable.
- R4: A hit happens when all of these hold in the same cycle: `tm_tick` is high, `tm_sec` is 0x00, `tm_min` equals the alarm minute, `tm_hour` equals the alarm hour, and the mask bit for `tm_wday` is set. The pending flag is 1 from the clock edge that samples the hit.
- R5: When the mask bit for the current weekday is clear, matching minute and hour give no hit. A mask with several bits set gives a hit on each selected day.
- R6: A tick whose seconds value is not 0x00 never gives a hit, even when minute, hour and day all match.
- R7: While `tm_hold` is high, no hit is taken.
- R8: `alarm_irq` is high exactly when the pending flag is 1 and the enable is 1. The flag latches even while the enable is 0, so setting the enable later raises the interrupt.
- R9: Bit 0 of the status register (offset 0x3C) reads the pending flag. Writing 1 to it clears the flag. Writing 0 leaves the flag unchanged.
- R10: When a clear write and a hit fall in the same cycle, the flag ends up set.
- R11: A `tm_wday` value of 7 or more never gives a hit, whatever the mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tm_tick | input | 1 | One-cycle pulse when the seconds value updates |
| tm_sec | input | 8 | Current seconds, BCD |
| tm_min | input | 8 | Current minutes, BCD |
| tm_hour | input | 8 | Current hours, BCD, 24-hour |
| tm_wday | input | 3 | Current weekday, 0 to 6 |
| tm_hold | input | 1 | Calendar counter held for update |
| alarm_irq | output | 1 | Alarm interrupt, level |

## Verification
A wrong compare or a wrong mask index shows up as a status bit that differs from the bench's model. This is visible in the cycle right after the tick edge, because the bench reads status after every tick. If the pending flag fails to stick, the next status read shows the fault. If the flag fails to clear, the read after a one-write shows it. A broken gate between the enable and the flag shows up on `alarm_irq` at the same read point. The bench checks this with the enable both set and clear. Random alarm settings and times are mixed with directed cases: a clear in the same cycle as a hit, an invalid weekday, hold, and a nonzero seconds value.

// File: rtl/wk_alarm_pkg.sv
package wk_alarm_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int NDAYS  = 7;
    localparam int WDAY_W = $clog2(NDAYS + 1);
    localparam int EN_BIT = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h3C;
    localparam logic [ADDR_W-1:0] OFS_AMIN = 8'h40;
    localparam logic [ADDR_W-1:0] OFS_AHR  = 8'h44;
    localparam logic [ADDR_W-1:0] OFS_DAYS = 8'h48;

    typedef struct packed {
        logic [MIN_W-1:0]  min;
        logic [HOUR_W-1:0] hour;
        logic [NDAYS-1:0]  days;
        logic              en;
    } alm_cfg_t;

    typedef struct packed {
        logic              tick;
        logic              hold;
        logic [7:0]        sec;
        logic [7:0]        min;
        logic [7:0]        hour;
        logic [WDAY_W-1:0] wday;
    } tm_view_t;

    function automatic logic day_selected(input logic [NDAYS-1:0] days,
                                          input logic [WDAY_W-1:0] wday);
        logic sel;
        sel = 1'b0;
        for (int i = 0; i < NDAYS; i++) begin
            if (wday == WDAY_W'(i)) sel = days[i];
        end
        return sel;
    endfunction
endpackage

// File: rtl/wk_alarm_regs.sv
module wk_alarm_regs
    import wk_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pend,
    output alm_cfg_t          cfg,
    output logic              clr_req,
    output logic [DATA_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (we) begin
            case (addr)
                OFS_CTRL: cfg.en   <= wdata[EN_BIT];
                OFS_AMIN: cfg.min  <= wdata[MIN_W-1:0];
                OFS_AHR:  cfg.hour <= wdata[HOUR_W-1:0];
                OFS_DAYS: cfg.days <= wdata[NDAYS-1:0];
                default: ;
            endcase
        end
    end

    assign clr_req = we && (addr == OFS_STAT) && wdata[0];

    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: rdata[EN_BIT]       = cfg.en;
            OFS_STAT: rdata[0]            = pend;
            OFS_AMIN: rdata[MIN_W-1:0]    = cfg.min;
            OFS_AHR:  rdata[HOUR_W-1:0]   = cfg.hour;
            OFS_DAYS: rdata[NDAYS-1:0]    = cfg.days;
            default:  rdata = '0;
        endcase
    end

    a_r3_en_follows_ctrl_write: assert property (@(posedge clk) disable iff (rst)
        (we && addr == OFS_CTRL) |=> (cfg.en == $past(wdata[EN_BIT])));
    a_r2_mask_holds_without_write: assert property (@(posedge clk) disable iff (rst)
        !(we && addr == OFS_DAYS) |=> $stable(cfg.days));
endmodule

// File: rtl/wk_alarm_match.sv
module wk_alarm_match
    import wk_alarm_pkg::*;
(
    input  alm_cfg_t cfg,
    input  tm_view_t tm,
    output logic     hit
);
    logic minute_edge;
    logic time_eq;
    logic day_ok;

    assign minute_edge = tm.tick && !tm.hold && (tm.sec == 8'h00);
    assign time_eq     = (tm.min == 8'(cfg.min)) && (tm.hour == 8'(cfg.hour));
    assign day_ok      = day_selected(cfg.days, tm.wday);
    assign hit         = minute_edge && time_eq && day_ok;
endmodule

// File: rtl/wk_alarm_pending.sv
module wk_alarm_pending (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)       pend <= 1'b0;
        else if (hit)  pend <= 1'b1;
        else if (clr)  pend <= 1'b0;
    end

    a_r4_hit_sets_flag: assert property (@(posedge clk) disable iff (rst)
        hit |=> pend);
    a_r9_clear_drops_flag: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !pend);
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);
    a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (!pend && !hit) |=> !pend);
endmodule

// File: rtl/wk_alarm_top.sv
module wk_alarm_top
    import wk_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tm_tick,
    input  logic [7:0]        tm_sec,
    input  logic [7:0]        tm_min,
    input  logic [7:0]        tm_hour,
    input  logic [WDAY_W-1:0] tm_wday,
    input  logic              tm_hold,
    output logic              alarm_irq
);
    alm_cfg_t cfg;
    tm_view_t tm;
    logic     hit;
    logic     clr_req;
    logic     pend;

    assign tm = '{tick: tm_tick, hold: tm_hold, sec: tm_sec,
                  min: tm_min, hour: tm_hour, wday: tm_wday};

    wk_alarm_regs u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
        .pend(pend), .cfg(cfg), .clr_req(clr_req), .rdata(bus_rdata)
    );

    wk_alarm_match u_match (.cfg(cfg), .tm(tm), .hit(hit));

    wk_alarm_pending u_pend (
        .clk(clk), .rst(rst), .hit(hit), .clr(clr_req), .pend(pend)
    );

    assign alarm_irq = pend && cfg.en;

    a_r7_hold_blocks_set: assert property (@(posedge clk) disable iff (rst)
        (!pend && tm_hold && !clr_req) |=> !pend);
    a_r6_set_needs_zero_sec: assert property (@(posedge clk) disable iff (rst)
        (!pend && !(tm_tick && tm_sec == 8'h00)) |=> !pend);
    a_r10_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_req && hit) |=> pend);
    a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (rst)
        alarm_irq |-> (cfg.en && pend));
endmodule

// File: tb/test_wk_alarm_top.sv
`timescale 1ns/1ps
module test_wk_alarm_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tm_tick = 1'b0;
    logic [7:0]  tm_sec = 8'h00, tm_min = 8'h00, tm_hour = 8'h00;
    logic [2:0]  tm_wday = 3'd0;
    logic        tm_hold = 1'b0;
    logic        alarm_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    wk_alarm_top i_wk_alarm_top (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tm_tick(tm_tick),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_wday(tm_wday),
        .tm_hold(tm_hold), .alarm_irq(alarm_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic tick(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [2:0] w, input logic hold);
        @(negedge clk);
        tm_tick = 1'b1; tm_sec = s; tm_min = m; tm_hour = h; tm_wday = w; tm_hold = hold;
        @(negedge clk);
        tm_tick = 1'b0; tm_hold = 1'b0;
    endtask

    function automatic logic model_hit(input logic [6:0] am, input logic [5:0] ah,
                                       input logic [6:0] mask, input logic [7:0] s,
                                       input logic [7:0] m, input logic [7:0] h,
                                       input logic [2:0] w, input logic hold);
        if (hold || s != 8'h00) return 1'b0;
        if (m != {1'b0, am} || h != {2'b00, ah}) return 1'b0;
        if (w > 3'd6) return 1'b0;
        return mask[w];
    endfunction

    function automatic logic [7:0] rand_bcd(input int lim);
        int v;
        v = $urandom_range(lim - 1);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    initial begin
        logic [31:0] r;
        void'($urandom(32'h5EED_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(8'h40, r); check("R1 amin", r, 0);
        rd(8'h44, r); check("R1 ahour", r, 0);
        rd(8'h48, r); check("R1 mask", r, 0);
        rd(8'h04, r); check("R1 ctrl", r, 0);
        rd(8'h3C, r); check("R1 status", r, 0);
        check("R1 irq", 32'(alarm_irq), 0);

        // R2 readback with masking
        wr(8'h40, 32'hFFFF_FFD9); rd(8'h40, r); check("R2 amin", r, 32'h59);
        wr(8'h44, 32'hFFFF_FFE3); rd(8'h44, r); check("R2 ahour", r, 32'h23);
        wr(8'h48, 32'hFFFF_FF95); rd(8'h48, r); check("R2 mask", r, 32'h15);

        // R3 enable bit
        wr(8'h04, 32'h10); rd(8'h04, r); check("R3 en set", r, 32'h10);
        wr(8'h04, 32'h0);  rd(8'h04, r); check("R3 en clr", r, 32'h0);

        // R4/R8 match with enable off, then enable later
        wr(8'h40, 32'h30); wr(8'h44, 32'h12); wr(8'h48, 32'h15); // days 0,2,4
        tick(8'h00, 8'h30, 8'h12, 3'd2, 1'b0);
        rd(8'h3C, r); check("R4 hit sets flag", r, 1);
        check("R8 irq gated off", 32'(alarm_irq), 0);
        wr(8'h04, 32'h10);
        #1 check("R8 irq after enable", 32'(alarm_irq), 1);

        // R9 write 0 no effect, write 1 clears
        wr(8'h3C, 32'h0); rd(8'h3C, r); check("R9 write0 keeps", r, 1);
        wr(8'h3C, 32'h1); rd(8'h3C, r); check("R9 write1 clears", r, 0);
        check("R8 irq low after clear", 32'(alarm_irq), 0);

        // R5 unselected day, then another selected day
        tick(8'h00, 8'h30, 8'h12, 3'd3, 1'b0);
        rd(8'h3C, r); check("R5 unselected day", r, 0);
        tick(8'h00, 8'h30, 8'h12, 3'd4, 1'b0);
        rd(8'h3C, r); check("R5 second selected day", r, 1);
        wr(8'h3C, 32'h1);

        // R6 nonzero seconds
        tick(8'h01, 8'h30, 8'h12, 3'd0, 1'b0);
        rd(8'h3C, r); check("R6 nonzero sec", r, 0);

        // R7 hold
        tick(8'h00, 8'h30, 8'h12, 3'd0, 1'b1);
        rd(8'h3C, r); check("R7 hold", r, 0);

        // R11 invalid weekday with full mask
        wr(8'h48, 32'h7F);
        tick(8'h00, 8'h30, 8'h12, 3'd7, 1'b0);
        rd(8'h3C, r); check("R11 wday 7", r, 0);

        // R10 clear and hit same cycle
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'h3C; bus_wdata = 32'h1;
        tm_tick = 1'b1; tm_sec = 8'h00; tm_min = 8'h30; tm_hour = 8'h12; tm_wday = 3'd6;
        @(negedge clk);
        bus_we = 1'b0; tm_tick = 1'b0;
        rd(8'h3C, r); check("R10 set wins", r, 1);
        wr(8'h3C, 32'h1);

        // R3 writing 0 to control disables irq
        tick(8'h00, 8'h30, 8'h12, 3'd1, 1'b0);
        #1 check("R8 irq on", 32'(alarm_irq), 1);
        wr(8'h04, 32'h0);
        #1 check("R3 write0 disables irq", 32'(alarm_irq), 0);
        wr(8'h3C, 32'h1);

        // random R4/R5/R6/R7/R8/R11
        for (int it = 0; it < 60; it++) begin
            logic [6:0] am; logic [5:0] ah; logic [6:0] mk; logic en;
            logic [7:0] s, m, h; logic [2:0] w; logic hd; logic e;
            am = 7'(rand_bcd(60)); ah = 6'(rand_bcd(24)); mk = 7'($urandom);
            en = 1'($urandom);
            wr(8'h40, 32'(am)); wr(8'h44, 32'(ah)); wr(8'h48, 32'(mk));
            wr(8'h04, en ? 32'h10 : 32'h0);
            if ($urandom_range(1)) begin m = {1'b0, am}; h = {2'b00, ah}; end
            else begin m = rand_bcd(60); h = rand_bcd(24); end
            s  = ($urandom_range(3) != 0) ? 8'h00 : rand_bcd(60);
            w  = 3'($urandom);
            hd = ($urandom_range(6) == 0);
            e  = model_hit(am, ah, mk, s, m, h, w, hd);
            tick(s, m, h, w, hd);
            rd(8'h3C, r); check("R4 random flag", r, 32'(e));
            check("R8 random irq", 32'(alarm_irq), 32'(e && en));
            wr(8'h3C, 32'h1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule